// File: doc/BRIEF.md
# Prefilled Parallel-to-Serial Multichannel Audio Streamer

This block sits between a microcontroller with a byte-wide parallel bus and a multichannel audio converter that needs a serial link faster than the controller can drive. The controller writes bytes one at a time. The block holds them in an on-chip queue. Once enough bytes are queued, it sends them out as a continuous serial stream with its own bit clock and a frame marker. The bit clock is derived from the fast system clock by integer division.

A frame holds eight channels of 24-bit samples, for 192 bits in total. Three consecutive queued bytes form one sample, and the first of those bytes is the sample's most significant byte. Streaming waits until a prefill threshold of bytes is queued, then runs frame after frame with no gaps. If the queue cannot supply a whole sample, the rest of the frame is sent as zeros. The block then stops its bit clock and waits for the threshold again.

Top module: `dac_stream_feeder`

## Requirements
- R1: While `rst_n` is low and right after it is released, `sclk`, `sdata` and `fsync` are low, and `fifo_full`, `overflow` and `underflow` are 0.
- R2: `sclk` shows no rising edge while fewer than PREFILL (default 100) bytes are queued. Streaming starts only after the queue holds at least PREFILL bytes.
- R3: Bytes are sent in the order they were written, each most significant bit first. Three bytes form one 24-bit sample, and the first byte written is the sample's most significant byte. Channel 0 is the first sample of each frame, which holds 8 samples (192 bits).
- R4: `fsync` is high for exactly one bit period in each frame, during the first bit of channel 0, so its high bits are 192 bits apart.
- R5: With `rate_sel`=0, one `sclk` period is 2 system clocks, and `sclk` is high for 1 of them. With `rate_sel`=1, periods alternate between 2 and 3 system clocks, for an average of 2.5 (40 MHz from 100 MHz). `sclk` is never high for more than one system clock.
- R6: `sdata` changes only in a system cycle in which `sclk` is low, so that it is steady at every `sclk` rising edge.
- R7: `fifo_full` is 1 when 128 bytes are queued. A write made while full is dropped and sets the sticky `overflow` flag. Bytes accepted before the queue filled are all streamed, in order.
- R8: At the start of a sample, if fewer than 3 bytes are queued, that sample and the rest of the frame are sent as zeros and the sticky `underflow` flag is set. After the frame, `sclk` stops low. Any leftover bytes stay queued and are the first ones sent once the threshold is reached again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (100 MHz in the target) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe, one byte per cycle in which it is high |
| wr_data | input | 8 | Byte to queue |
| rate_sel | input | 1 | 0: bit clock is the system clock divided by 2; 1: divide alternates between 2 and 3 |
| fifo_full | output | 1 | Queue holds 128 bytes |
| overflow | output | 1 | Sticky: a write was dropped because the queue was full |
| underflow | output | 1 | Sticky: a frame was padded with zeros because the queue ran short |
| sclk | output | 1 | Serial bit clock |
| sdata | output | 1 | Serial data, changes while `sclk` is low |
| fsync | output | 1 | Frame marker, high during the first bit of each frame |

## Verification
The hardest case to reach from the ports is the queue running short partway through a frame. That only happens when the byte count left at a sample boundary is not a multiple of three. The bench writes exactly the threshold of 100 bytes. Four full frames use 96 of them, the fifth frame's channel 0 uses three more, and channel 1 then finds a single byte. The stranded byte is expected to lead the next stream, which the bench starts at the alternating rate. Overflow is reached by writing bytes back to back, faster than the serializer drains the queue.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

  typedef enum logic {
    ST_WAIT_FILL = 1'b0,
    ST_STREAM    = 1'b1
  } stream_state_e;

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && (cnt_q != '0);

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    ovf_d  = ovf_q || (push && full);
    if (do_push) wptr_d = (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
    if (do_pop)  rptr_d = (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= din;
  end

  assign head     = mem[rptr_q];
  assign count    = cnt_q;
  assign overflow = ovf_q;

  always_ff @(posedge clk) begin
    if (rst_n) AST_NO_OVERFLOW: assert (cnt_q <= CW'(DEPTH)); // R7
  end

  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (full && cnt_q == $past(cnt_q))); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R7

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0)); // R8

endmodule

// File: rtl/bit_clock_gen.sv
module bit_clock_gen #(
  parameter int BASE_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rate_alt,
  output logic sclk,
  output logic fall_en
);
  localparam int CNT_W = $clog2(BASE_DIV + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ph_q, ph_d;
  logic             sclk_q, sclk_d;
  logic             last;

  assign last    = (cnt_q == ((ph_q && rate_alt) ? CNT_W'(BASE_DIV) : CNT_W'(BASE_DIV - 1)));
  assign fall_en = run && (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    ph_d   = ph_q;
    sclk_d = sclk_q;
    if (!run) begin
      cnt_d  = '0;
      ph_d   = 1'b0;
      sclk_d = 1'b0;
    end else if (last) begin
      cnt_d  = '0;
      ph_d   = ph_q ^ rate_alt;
      sclk_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == '0) sclk_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      ph_q   <= ph_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;

  AST_SCLK_SHORT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |=> !sclk_q); // R5

  AST_SCLK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !sclk_q) |=> !sclk_q); // R2

endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
  import dsf_pkg::*;
#(
  parameter int W            = 8,
  parameter int SAMPLE_BYTES = 3,
  parameter int CHANNELS     = 8,
  parameter int PREFILL      = 100,
  parameter int CW           = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall_en,
  input  logic [CW-1:0] fifo_count,
  input  logic [W-1:0]  fifo_head,
  output logic          pop,
  output logic          run,
  output logic          sdata,
  output logic          fsync,
  output logic          underflow
);
  localparam int BIT_W  = (W > 1) ? $clog2(W) : 1;
  localparam int BYTE_W = (SAMPLE_BYTES > 1) ? $clog2(SAMPLE_BYTES) : 1;
  localparam int CH_W   = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;

  stream_state_e     state_q, state_d;
  logic [BIT_W-1:0]  bib_q, bib_d;
  logic [BYTE_W-1:0] bis_q, bis_d;
  logic [CH_W-1:0]   ch_q, ch_d;
  logic [W-1:0]      sr_q, sr_d;
  logic              zf_q, zf_d;
  logic              sd_q, sd_d;
  logic              fs_q, fs_d;
  logic              uf_q, uf_d;
  logic              frame_first, short_q;

  assign frame_first = (bib_q == '0) && (bis_q == '0) && (ch_q == '0);
  assign short_q     = (fifo_count < CW'(SAMPLE_BYTES));

  always_comb begin
    state_d = state_q;
    bib_d   = bib_q;
    bis_d   = bis_q;
    ch_d    = ch_q;
    sr_d    = sr_q;
    zf_d    = zf_q;
    sd_d    = sd_q;
    fs_d    = fs_q;
    uf_d    = uf_q;
    pop     = 1'b0;
    case (state_q)
      ST_WAIT_FILL: begin
        if (fifo_count >= CW'(PREFILL)) begin
          state_d = ST_STREAM;
          bib_d   = '0;
          bis_d   = '0;
          ch_d    = '0;
          zf_d    = 1'b0;
        end
      end
      default: begin
        if (fall_en) begin
          if (frame_first && (zf_q || short_q)) begin
            state_d = ST_WAIT_FILL;
            sd_d    = 1'b0;
            fs_d    = 1'b0;
            zf_d    = 1'b0;
            if (!zf_q) uf_d = 1'b1;
          end else begin
            fs_d = frame_first;
            if ((bib_q == '0) && (bis_q == '0) && !zf_q && short_q) begin
              zf_d = 1'b1;
              uf_d = 1'b1;
            end
            if (zf_d) begin
              sd_d = 1'b0;
            end else if (bib_q == '0) begin
              pop  = 1'b1;
              sd_d = fifo_head[W-1];
              sr_d = {fifo_head[W-2:0], 1'b0};
            end else begin
              sd_d = sr_q[W-1];
              sr_d = {sr_q[W-2:0], 1'b0};
            end
            if (bib_q == BIT_W'(W - 1)) begin
              bib_d = '0;
              if (bis_q == BYTE_W'(SAMPLE_BYTES - 1)) begin
                bis_d = '0;
                ch_d  = (ch_q == CH_W'(CHANNELS - 1)) ? '0 : ch_q + 1'b1;
              end else begin
                bis_d = bis_q + 1'b1;
              end
            end else begin
              bib_d = bib_q + 1'b1;
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT_FILL;
      bib_q   <= '0;
      bis_q   <= '0;
      ch_q    <= '0;
      sr_q    <= '0;
      zf_q    <= 1'b0;
      sd_q    <= 1'b0;
      fs_q    <= 1'b0;
      uf_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      bib_q   <= bib_d;
      bis_q   <= bis_d;
      ch_q    <= ch_d;
      sr_q    <= sr_d;
      zf_q    <= zf_d;
      sd_q    <= sd_d;
      fs_q    <= fs_d;
      uf_q    <= uf_d;
    end
  end

  assign run       = (state_q == ST_STREAM);
  assign sdata     = sd_q;
  assign fsync     = fs_q;
  assign underflow = uf_q;

  AST_START_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> ($past(fifo_count) >= CW'(PREFILL))); // R2

  AST_FSYNC_IN_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |-> run); // R4

  AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow); // R8

endmodule

// File: rtl/dac_stream_feeder.sv
module dac_stream_feeder #(
  parameter int W            = 8,
  parameter int DEPTH        = 128,
  parameter int PREFILL      = 100,
  parameter int SAMPLE_BYTES = 3,
  parameter int CHANNELS     = 8,
  parameter int BASE_DIV     = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rate_sel,
  output logic         fifo_full,
  output logic         overflow,
  output logic         underflow,
  output logic         sclk,
  output logic         sdata,
  output logic         fsync
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  head;
  logic [CW-1:0] count;
  logic          pop, run, fall_en;

  byte_fifo #(.W(W), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .din(wr_data), .pop(pop),
    .head(head), .count(count), .full(fifo_full), .overflow(overflow)
  );

  bit_clock_gen #(.BASE_DIV(BASE_DIV)) bclk_i (
    .clk(clk), .rst_n(rst_n), .run(run), .rate_alt(rate_sel),
    .sclk(sclk), .fall_en(fall_en)
  );

  frame_serializer #(
    .W(W), .SAMPLE_BYTES(SAMPLE_BYTES), .CHANNELS(CHANNELS),
    .PREFILL(PREFILL), .CW(CW)
  ) ser_i (
    .clk(clk), .rst_n(rst_n), .fall_en(fall_en), .fifo_count(count),
    .fifo_head(head), .pop(pop), .run(run), .sdata(sdata),
    .fsync(fsync), .underflow(underflow)
  );

  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> !sclk); // R6

  AST_FSYNC_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fsync) |-> !sclk); // R4

endmodule

// File: tb/dac_stream_feeder_tb_top.sv
`timescale 1ns/1ps
module dac_stream_feeder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       rate_sel;
  logic       fifo_full, overflow, underflow, sclk, sdata, fsync;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dac_stream_feeder dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rate_sel(rate_sel), .fifo_full(fifo_full), .overflow(overflow),
    .underflow(underflow), .sclk(sclk), .sdata(sdata), .fsync(fsync)
  );

  // capture of every sclk rising edge, sampled on the falling system edge
  logic bits_a [4096];
  logic fs_a   [4096];
  int   per_a  [4096];
  int   nrise;
  int   since;
  logic cap_en = 1'b0;
  logic prev_sclk = 1'b0;
  logic prev_sd = 1'b0;
  int   r6_bad = 0;
  logic full_seen = 1'b0;

  always @(negedge clk) begin
    if (cap_en) begin
      since = since + 1;
      if (sclk && !prev_sclk && nrise < 4096) begin
        bits_a[nrise] = sdata;
        fs_a[nrise]   = fsync;
        per_a[nrise]  = since;
        nrise = nrise + 1;
        since = 0;
      end
      if (sclk && (sdata !== prev_sd)) r6_bad = r6_bad + 1;
      if (fifo_full) full_seen = 1'b1;
    end
    prev_sclk = sclk;
    prev_sd   = sdata;
  end

  function automatic logic [7:0] val(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] cap_byte(input int j);
    logic [7:0] b;
    for (int k = 0; k < 8; k++) b[7-k] = bits_a[8*j + k];
    return b;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_capture();
    @(negedge clk);
    nrise = 0; since = 0; r6_bad = 0; full_seen = 1'b0; cap_en = 1'b1;
  endtask

  task automatic push_bytes(input int first, input int n, input logic incr_mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = incr_mode ? 8'(first + i + 1) : val(first + i);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    cap_en = 1'b0;
    wr_en = 1'b0; wr_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!sclk && !sdata && !fsync, "R1 outputs low in reset", {sclk, sdata, fsync}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!sclk && !sdata && !fsync, "R1 outputs low after reset", {sclk, sdata, fsync}, 0);
    check(!fifo_full && !overflow && !underflow, "R1 flags clear", {fifo_full, overflow, underflow}, 0);
  endtask

  // 100 queued bytes give 4 full frames, channel 0 of frame 4, then zeros
  task automatic check_short_stream(input int base, input string tag);
    int bad_data = 0, bad_zero = 0, bad_fs = 0;
    check(nrise == 960, {tag, " R8 five frames then sclk stops"}, nrise, 960);
    for (int j = 0; j < 99; j++)
      if (cap_byte(j) !== val(base + j)) bad_data++;
    check(bad_data == 0, {tag, " R3 byte order and bit order"}, bad_data, 0);
    for (int j = 99; j < 120; j++)
      if (cap_byte(j) !== 8'h00) bad_zero++;
    check(bad_zero == 0, {tag, " R8 rest of frame zero"}, bad_zero, 0);
    for (int k = 0; k < nrise; k++)
      if (fs_a[k] !== ((k % 192) == 0)) bad_fs++;
    check(bad_fs == 0, {tag, " R4 fsync on first bit of frame"}, bad_fs, 0);
    check(r6_bad == 0, {tag, " R6 sdata steady while sclk high"}, r6_bad, 0);
    check(underflow == 1'b1, {tag, " R8 underflow sticky set"}, underflow, 1);
  endtask

  task automatic t_prefill_div2();
    rate_sel = 1'b0;
    do_reset();
    start_capture();
    push_bytes(0, 99, 1'b0);
    repeat (300) @(negedge clk);
    check(nrise == 0, "R2 no sclk below threshold", nrise, 0);
    check(underflow == 1'b0, "R8 no underflow before start", underflow, 0);
    push_bytes(99, 1, 1'b0);
    repeat (2500) @(negedge clk);
    check_short_stream(0, "div2");
    begin
      int bad_p = 0;
      for (int k = 1; k < nrise; k++) if (per_a[k] != 2) bad_p++;
      check(bad_p == 0, "R5 divide-by-2 period", bad_p, 0);
    end
  endtask

  task automatic t_restart_alt();
    rate_sel = 1'b1;
    start_capture();
    push_bytes(100, 99, 1'b0);
    repeat (3000) @(negedge clk);
    check_short_stream(99, "alt");
    begin
      int bad_p = 0;
      for (int k = 1; k + 1 < nrise; k++)
        if (!((per_a[k] == 2 || per_a[k] == 3) && per_a[k] + per_a[k+1] == 5)) bad_p++;
      check(bad_p == 0, "R5 alternating 2/3 period", bad_p, 0);
    end
  endtask

  task automatic t_overflow();
    int nbytes, last, bad_ord, nz;
    rate_sel = 1'b0;
    do_reset();
    start_capture();
    push_bytes(0, 140, 1'b1);
    check(full_seen == 1'b1, "R7 full flag asserted", full_seen, 1);
    check(overflow == 1'b1, "R7 overflow sticky set", overflow, 1);
    repeat (3500) @(negedge clk);
    check(overflow == 1'b1, "R7 overflow still set", overflow, 1);
    check(fifo_full == 1'b0, "R7 full clears after drain", fifo_full, 0);
    nbytes = nrise / 8;
    bad_ord = 0;
    for (int j = 0; j < 128; j++)
      if (cap_byte(j) !== 8'(j + 1)) bad_ord++;
    check(bad_ord == 0, "R7 bytes before full all streamed", bad_ord, 0);
    last = 0; nz = 0; bad_ord = 0;
    for (int j = 0; j < nbytes; j++) begin
      if (cap_byte(j) != 0) begin
        if (int'(cap_byte(j)) <= last || nz != j) bad_ord++;
        last = int'(cap_byte(j));
        nz++;
      end
    end
    check(bad_ord == 0, "R7 later bytes ordered, zeros only trailing", bad_ord, 0);
    check(nz < 140, "R7 writes while full dropped", nz, 139);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; rate_sel = 1'b0;
    nrise = 0; since = 0;
    t_prefill_div2();
    t_restart_alt();
    t_overflow();
    do_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule